// File: doc/BRIEF.md
# Double-Buffered Bit-Level Crosspoint Switch

This block connects a set of single-bit input ports to an equal number of single-bit output ports. Each output owns a connection entry with three fields: an enable, a data-path mode (flow-through or registered), and the index of the input it follows. Several outputs can name the same input, so a single input can drive any number of outputs. No connection ever limits another, so the matrix never blocks.

Entries are written one at a time into a shadow bank through a parallel address/data port. This does not change the live connections. A single update strobe copies every shadow entry into the active bank on one clock edge, so a complete new connection pattern takes effect on one cycle. Either bank can be read back through a registered read port. A write that names a nonexistent output or input is refused and raises an error flag.

Top module: `xbar_matrix`

## Requirements
- R1: After synchronous reset, every entry in both banks is zero (disabled), every `dout` bit is 0, and readback of any entry returns 0.
- R2: A write changes only the shadow bank. The active bank and `dout` keep their values until an update.
- R3: When `cfg_update` is sampled high, every active entry takes its shadow value on that same edge, so all outputs switch together.
- R4: If a valid write and `cfg_update` fall in the same cycle, the active bank receives the newly written value.
- R5: An enabled entry whose mode bit (bit IDX_W) is 0 gives `dout[o] = din[src]` combinationally, in the same cycle.
- R6: An enabled entry whose mode bit is 1 gives the value of `din[src]` sampled at the previous rising clock edge.
- R7: An output whose enable bit (bit IDX_W+1) is 0 drives 0, whatever `din` is.
- R8: Any number of outputs may name the same source, and each of them follows that source.
- R9: `rd_addr` bit IDX_W selects the bank (0 = shadow, 1 = active) and the lower bits select the entry. `rd_data` holds that entry one cycle later.
- R10: A write whose address or source index (bits IDX_W-1:0) is not below NPORTS leaves the entry unchanged and sets `wr_err` for the following cycle. Every other cycle has `wr_err` low.
- R11: Readback of an entry index not below NPORTS returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the shadow bank |
| cfg_addr | input | IDX_W | Output index whose entry is written |
| cfg_wdata | input | IDX_W+2 | Entry written: {enable, registered, source} |
| cfg_update | input | 1 | Copies the shadow bank into the active bank |
| rd_addr | input | IDX_W+1 | {bank select, entry index} for readback |
| rd_data | output | IDX_W+2 | Registered readback entry |
| wr_err | output | 1 | Pulses for one cycle after a refused write |
| din | input | NPORTS | Input port data |
| dout | output | NPORTS | Output port data |

## Verification
A write or update issued in cycle k changes the stored banks on the edge that ends cycle k. Readback needs one more registered stage, so `rd_data` is sampled just after the edge that follows the cycle in which `rd_addr` was presented. `wr_err` is sampled just after the edge on which the refused write was taken. Flow-through outputs are checked in the same cycle the inputs are driven, at the falling edge. For registered outputs, the bench confirms the old value at that falling edge and then the new value after the next rising edge. All stimulus changes 1 ns after a rising edge, so every sample sees settled values.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  typedef enum logic {BANK_SHADOW = 1'b0, BANK_ACTIVE = 1'b1} bank_sel_e;

  function automatic logic index_ok(input int idx, input int n);
    return idx < n;
  endfunction
endpackage

// File: rtl/xbar_cfg_bank.sv
module xbar_cfg_bank #(
  parameter int NPORTS = 6,
  parameter int IDX_W  = 3,
  parameter int EW     = IDX_W + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [IDX_W-1:0]     waddr,
  input  logic [EW-1:0]        wdata,
  input  logic                 update,
  input  logic [IDX_W:0]       raddr,
  output logic [EW-1:0]        rdata,
  output logic                 werr,
  output logic [NPORTS*EW-1:0] act_flat
);
  import xbar_pkg::*;

  logic [EW-1:0] shadow_q [NPORTS];
  logic [EW-1:0] active_q [NPORTS];
  logic [EW-1:0] shadow_d [NPORTS];
  logic          wr_ok;
  logic [IDX_W-1:0] ridx;
  bank_sel_e     rsel;

  assign wr_ok = we && index_ok(int'(waddr), NPORTS)
                    && index_ok(int'(wdata[IDX_W-1:0]), NPORTS);
  assign ridx  = raddr[IDX_W-1:0];
  assign rsel  = bank_sel_e'(raddr[IDX_W]);

  // next shadow contents, including a write in this cycle
  always_comb begin
    for (int i = 0; i < NPORTS; i++)
      shadow_d[i] = (wr_ok && int'(waddr) == i) ? wdata : shadow_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPORTS; i++) begin
        shadow_q[i] <= '0;
        active_q[i] <= '0;
      end
      werr  <= 1'b0;
      rdata <= '0;
    end else begin
      for (int i = 0; i < NPORTS; i++) begin
        shadow_q[i] <= shadow_d[i];
        if (update) active_q[i] <= shadow_d[i];
      end
      werr <= we && !wr_ok;
      if (!index_ok(int'(ridx), NPORTS))
        rdata <= '0;
      else if (rsel == BANK_ACTIVE)
        rdata <= active_q[ridx];
      else
        rdata <= shadow_q[ridx];
    end
  end

  for (genvar g = 0; g < NPORTS; g++) begin : g_flat
    assign act_flat[g*EW +: EW] = active_q[g];
  end
endmodule

// File: rtl/xbar_out_sel.sv
module xbar_out_sel #(
  parameter int NPORTS = 6,
  parameter int IDX_W  = 3,
  parameter int EW     = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPORTS-1:0] din,
  input  logic [EW-1:0]     entry,
  output logic              dout_bit
);
  logic             en;
  logic             regd;
  logic [IDX_W-1:0] src;
  logic             picked;
  logic             held_q;

  assign en     = entry[EW-1];
  assign regd   = entry[EW-2];
  assign src    = entry[IDX_W-1:0];
  assign picked = din[src];

  always_ff @(posedge clk) begin
    if (rst) held_q <= 1'b0;
    else     held_q <= picked;
  end

  always_comb begin
    if (!en)       dout_bit = 1'b0;
    else if (regd) dout_bit = held_q;
    else           dout_bit = picked;
  end
endmodule

// File: rtl/xbar_matrix.sv
module xbar_matrix #(
  parameter int NPORTS = 6,
  localparam int IDX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int EW    = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_addr,
  input  logic [EW-1:0]     cfg_wdata,
  input  logic              cfg_update,
  input  logic [IDX_W:0]    rd_addr,
  output logic [EW-1:0]     rd_data,
  output logic              wr_err,
  input  logic [NPORTS-1:0] din,
  output logic [NPORTS-1:0] dout
);
  logic [NPORTS*EW-1:0] act_flat;

  xbar_cfg_bank #(.NPORTS(NPORTS), .IDX_W(IDX_W), .EW(EW)) bank_i (
    .clk(clk), .rst(rst), .we(cfg_we), .waddr(cfg_addr), .wdata(cfg_wdata),
    .update(cfg_update), .raddr(rd_addr), .rdata(rd_data), .werr(wr_err),
    .act_flat(act_flat)
  );

  for (genvar o = 0; o < NPORTS; o++) begin : g_out
    xbar_out_sel #(.NPORTS(NPORTS), .IDX_W(IDX_W), .EW(EW)) sel_i (
      .clk(clk), .rst(rst), .din(din), .entry(act_flat[o*EW +: EW]),
      .dout_bit(dout[o])
    );
  end
endmodule

// File: rtl/xbar_matrix_chk.sv
module xbar_matrix_chk #(
  parameter int NPORTS = 6,
  parameter int IDX_W  = 3,
  parameter int EW     = IDX_W + 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cfg_we,
  input logic [IDX_W-1:0]     cfg_addr,
  input logic [EW-1:0]        cfg_wdata,
  input logic                 cfg_update,
  input logic [IDX_W:0]       rd_addr,
  input logic [EW-1:0]        rd_data,
  input logic                 wr_err,
  input logic [NPORTS-1:0]    dout,
  input logic [NPORTS*EW-1:0] act_flat
);
  logic bad_wr;
  logic good_wr;
  assign bad_wr  = cfg_we && (int'(cfg_addr) >= NPORTS
                              || int'(cfg_wdata[IDX_W-1:0]) >= NPORTS);
  assign good_wr = cfg_we && !bad_wr;

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> dout == '0);

  assert_active_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(cfg_update) |-> $stable(act_flat));

  assert_same_cycle_R4: assert property (@(posedge clk) disable iff (rst)
    good_wr && cfg_update |=>
      act_flat[int'($past(cfg_addr))*EW +: EW] == $past(cfg_wdata));

  assert_err_raise_R10: assert property (@(posedge clk) disable iff (rst)
    bad_wr |=> wr_err);

  assert_err_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !bad_wr |=> !wr_err);

  assert_rd_range_R11: assert property (@(posedge clk) disable iff (rst)
    int'(rd_addr[IDX_W-1:0]) >= NPORTS |=> rd_data == '0);
endmodule

bind xbar_matrix xbar_matrix_chk #(.NPORTS(NPORTS), .IDX_W(IDX_W), .EW(EW)) chk_i (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .cfg_update(cfg_update), .rd_addr(rd_addr),
  .rd_data(rd_data), .wr_err(wr_err), .dout(dout), .act_flat(act_flat)
);

// File: tb/xbar_matrix_tb_top.sv
module xbar_matrix_tb_top;
  localparam int N  = 6;
  localparam int IW = 3;
  localparam int EW = IW + 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_addr = '0;
  logic [EW-1:0] cfg_wdata = '0;
  logic          cfg_update = 1'b0;
  logic [IW:0]   rd_addr = '0;
  logic [EW-1:0] rd_data;
  logic          wr_err;
  logic [N-1:0]  din = '0;
  logic [N-1:0]  dout;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  xbar_matrix #(.NPORTS(N)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_update(cfg_update), .rd_addr(rd_addr),
    .rd_data(rd_data), .wr_err(wr_err), .din(din), .dout(dout)
  );

  // {din, expected dout} with out0,out1,out5<-in2, out2<-in5, out4<-in0, out3 off
  localparam logic [11:0] VEC [8] = '{
    {6'b000000, 6'b000000}, {6'b000100, 6'b100011},
    {6'b100000, 6'b000100}, {6'b000001, 6'b010000},
    {6'b111111, 6'b110111}, {6'b001010, 6'b000000},
    {6'b100101, 6'b110111}, {6'b011011, 6'b010000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [EW-1:0] w, input logic upd);
    cfg_we = 1'b1; cfg_addr = IW'(a); cfg_wdata = w; cfg_update = upd;
    @(posedge clk); #1;
    cfg_we = 1'b0; cfg_update = 1'b0;
  endtask

  task automatic rd(input logic [IW:0] a);
    rd_addr = a;
    @(posedge clk); #1;
  endtask

  initial begin
    #4000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    din = '1;
    @(negedge clk);
    check("R1 dout after reset", 32'(dout), 0);
    check("R7 disabled outputs", 32'(dout), 0);
    rd(4'b0000); check("R1 shadow entry 0", 32'(rd_data), 0);
    rd(4'b1000); check("R1 active entry 0", 32'(rd_data), 0);

    wr(0, 5'b10010, 1'b0);
    wr(1, 5'b10010, 1'b0);
    wr(2, 5'b10101, 1'b0);
    wr(4, 5'b10000, 1'b0);
    wr(5, 5'b10010, 1'b0);
    @(negedge clk);
    check("R2 dout before update", 32'(dout), 0);
    rd(4'b0000); check("R9 shadow readback", 32'(rd_data), 32'b10010);
    rd(4'b1000); check("R2 active untouched", 32'(rd_data), 0);

    cfg_update = 1'b1; @(posedge clk); #1 cfg_update = 1'b0;
    for (int i = 0; i < 8; i++) begin
      din = VEC[i][11:6];
      @(negedge clk);
      check("R3 R5 R8 table", 32'(dout), 32'(VEC[i][5:0]));
    end

    wr(2, 5'b10111, 1'b0);
    check("R10 bad source flag", 32'(wr_err), 1);
    rd(4'b0010); check("R10 entry kept", 32'(rd_data), 32'b10101);
    check("R10 flag clears", 32'(wr_err), 0);
    wr(6, 5'b10001, 1'b0);
    check("R10 bad address flag", 32'(wr_err), 1);

    din = 6'b000010;
    wr(3, 5'b10001, 1'b1);
    @(negedge clk);
    check("R4 write with update", 32'(dout), 32'b001000);
    rd(4'b1011); check("R9 active readback", 32'(rd_data), 32'b10001);
    rd(4'b1111); check("R11 out of range read", 32'(rd_data), 0);

    wr(4, 5'b11000, 1'b1);
    din = 6'b000001;
    @(negedge clk);
    check("R6 registered not yet", 32'(dout[4]), 0);
    @(posedge clk); #1;
    check("R6 registered one edge later", 32'(dout[4]), 1);
    din = 6'b000000;
    @(negedge clk);
    check("R6 registered holds", 32'(dout[4]), 1);
    @(posedge clk); #1;
    check("R6 registered follows", 32'(dout[4]), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule